// File: doc/BRIEF.md
# Interrupt CPU Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best pending candidate as an ID, an 8-bit priority and a valid flag. The block checks that candidate against several conditions: the interface enable, the distributor forwarding enable, a programmable priority mask and the priority of the interrupt the processor is already servicing. When all of them allow it, the block raises a registered interrupt request. A lower priority value means a more urgent interrupt.

Software uses a small register port. Reading the acknowledge register takes the candidate. The ID is returned, the candidate's priority is pushed onto a stack of active priorities, and the distributor receives a one-cycle acknowledge pulse. Writing that ID to the end-of-interrupt register pops the stack, which drops the running priority back to the level of the interrupt that was preempted, and sends a one-cycle end pulse. A binary point setting decides which priority bits count as the group priority for preemption.

Top module: `cpuif_top`

## Requirements
- R1: `irq_out` is high only when control bit 0 is set, `dist_en` is high and a candidate is valid. It follows the qualifying input one cycle later.
- R2: A candidate is signalled only if its priority is strictly below the priority mask (offset 1, bits [7:0], reset value 0).
- R3: With binary point N (offset 2, bits [2:0]), the group priority is priority[7:N+1]. When nothing is active, any candidate that passes the mask may be taken. Otherwise the candidate's group must be strictly lower than the group of the top active entry, so a candidate in the same group never preempts, even with a lower subpriority.
- R4: A read of offset 3 returns the candidate ID when signalling is allowed and makes the candidate active. One cycle later `ack_pulse` is high for exactly one cycle with `ack_id` equal to that ID.
- R5: A read of offset 3 returns the spurious ID 1023 and produces no pulse in any of these cases: interface disabled, distributor disabled, no valid candidate, mask or preemption failing, or all 8 stack entries in use. A full stack also holds `irq_out` low.
- R6: A write to offset 4 whose bits [23:0] equal the ID on top of the active stack removes that entry. One cycle later `eoi_pulse` is high for one cycle with `eoi_id` equal to that ID. Nested interrupts are ended last-taken first.
- R7: A write to offset 4 with any other ID, or with an empty stack, leaves the stack unchanged and produces no pulse. It sets `eoi_err`, which stays set until reset.
- R8: A read of offset 5 returns the priority of the top active entry in bits [7:0], or 0xFF when no entry is active.
- R9: A read of offset 6 returns the candidate ID when a candidate is valid and `dist_en` is high, and 1023 otherwise. It has no side effect on the stack or on the pulses.
- R10: Read data appears on `reg_rdata` one cycle after `reg_rd`, with `reg_rvalid` high for that cycle. Offsets 0, 1 and 2 read back their written fields, and the fields are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_en | input | 1 | Distributor forwarding enabled |
| cand_valid | input | 1 | Candidate present |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| reg_rvalid | output | 1 | Read data valid |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_pulse | output | 1 | Acknowledge pulse to the distributor |
| ack_id | output | 10 | ID acknowledged |
| eoi_pulse | output | 1 | End-of-interrupt pulse to the distributor |
| eoi_id | output | 10 | ID ended |
| eoi_err | output | 1 | Sticky mismatched end-of-interrupt flag |

## Verification
The hardest state to reach is a full active stack. Only a chain of eight acknowledges can fill it, and each one must be in a strictly lower group than the entry before it. The bench sets the binary point to zero and presents priorities that fall by 0x10 at each step. With the eighth entry in place it offers a ninth candidate at priority 0, and checks both the request line and the spurious acknowledge. It then unwinds the stack, starting with one deliberately out-of-order end write. The preemption rule is swept over every binary point and a range of priority pairs, with the expected result computed from shifted group values.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int PRIO_W = 8;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_MASK = 3'd1;
  localparam logic [2:0] A_BPT  = 3'd2;
  localparam logic [2:0] A_ACK  = 3'd3;
  localparam logic [2:0] A_EOI  = 3'd4;
  localparam logic [2:0] A_RUN  = 3'd5;
  localparam logic [2:0] A_HPP  = 3'd6;
  localparam int SPURIOUS = 1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;
endpackage

// File: rtl/cpuif_stack.sv
module cpuif_stack #(
  parameter int DEPTH = 8,
  parameter int PW    = 8,
  parameter int IW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [PW-1:0] push_prio,
  input  logic [IW-1:0] push_id,
  input  logic          pop,
  output logic [PW-1:0] top_prio,
  output logic [IW-1:0] top_id,
  output logic          empty,
  output logic          full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] prio_mem [DEPTH];
  logic [IW-1:0] id_mem   [DEPTH];
  logic [CW-1:0] cnt;
  logic [AW-1:0] wr_ptr, top_ptr;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign wr_ptr  = AW'(cnt);
  assign top_ptr = AW'(cnt - CW'(1));

  always_ff @(posedge clk) begin
    if (push && !full) begin
      prio_mem[wr_ptr] <= push_prio;
      id_mem[wr_ptr]   <= push_id;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (push && !full) cnt <= cnt + CW'(1);
    else if (pop && !empty) cnt <= cnt - CW'(1);
  end

  assign top_prio = empty ? '1 : prio_mem[top_ptr];
  assign top_id   = empty ? '0 : id_mem[top_ptr];

  assert_no_push_full_R5: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_depth_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop) |=> $stable(cnt));
endmodule

// File: rtl/cpuif_gate.sv
module cpuif_gate #(
  parameter int PW = 8
) (
  input  logic          ctl_en,
  input  logic          dist_en,
  input  logic          cand_valid,
  input  logic [PW-1:0] cand_prio,
  input  logic [PW-1:0] mask,
  input  logic [2:0]    bpt,
  input  logic [PW-1:0] run_prio,
  input  logic          idle,
  input  logic          full,
  output logic          allow
);
  logic [PW-1:0] gmask;
  logic          below_mask, preempts;

  always_comb begin
    gmask      = {PW{1'b1}} << ({1'b0, bpt} + 4'd1);
    below_mask = cand_prio < mask;
    preempts   = idle || ((cand_prio & gmask) < (run_prio & gmask));
    allow      = ctl_en && dist_en && cand_valid && below_mask && preempts && !full;
  end
endmodule

// File: rtl/cpuif_top.sv
module cpuif_top
  import cpuif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dist_en,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              irq_out,
  output logic              ack_pulse,
  output logic [ID_W-1:0]   ack_id,
  output logic              eoi_pulse,
  output logic [ID_W-1:0]   eoi_id,
  output logic              eoi_err
);
  localparam logic [ID_W-1:0] SPUR_ID = ID_W'(SPURIOUS);
  localparam int HI_W = 24 - ID_W;

  logic              ctl_en;
  logic [PRIO_W-1:0] pmask;
  logic [2:0]        bpt;
  logic [PRIO_W-1:0] top_prio;
  logic [ID_W-1:0]   top_id;
  logic              st_empty, st_full, allow;
  logic              acc_ack, acc_eoi, take, eoi_hit, eoi_miss;
  logic [DATA_W-1:0] rd_mux;

  cpuif_stack #(.DEPTH(DEPTH), .PW(PRIO_W), .IW(ID_W)) u_stack (
    .clk(clk), .rst(rst),
    .push(take), .push_prio(cand_prio), .push_id(cand_id),
    .pop(eoi_hit),
    .top_prio(top_prio), .top_id(top_id),
    .empty(st_empty), .full(st_full)
  );

  cpuif_gate #(.PW(PRIO_W)) u_gate (
    .ctl_en(ctl_en), .dist_en(dist_en), .cand_valid(cand_valid),
    .cand_prio(cand_prio), .mask(pmask), .bpt(bpt),
    .run_prio(top_prio), .idle(st_empty), .full(st_full),
    .allow(allow)
  );

  assign acc_ack  = reg_rd && (reg_addr == A_ACK);
  assign acc_eoi  = reg_wr && (reg_addr == A_EOI);
  assign take     = acc_ack && allow;
  assign eoi_hit  = acc_eoi && !st_empty &&
                    (reg_wdata[ID_W-1:0] == top_id) &&
                    (reg_wdata[23:ID_W] == HI_W'(0));
  assign eoi_miss = acc_eoi && !eoi_hit;

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: rd_mux = DATA_W'(ctl_en);
      A_MASK: rd_mux = DATA_W'(pmask);
      A_BPT:  rd_mux = DATA_W'(bpt);
      A_ACK:  rd_mux = DATA_W'(take ? cand_id : SPUR_ID);
      A_RUN:  rd_mux = DATA_W'(top_prio);
      A_HPP:  rd_mux = DATA_W'((cand_valid && dist_en) ? cand_id : SPUR_ID);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en     <= 1'b0;
      pmask      <= '0;
      bpt        <= '0;
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      irq_out    <= 1'b0;
      ack_pulse  <= 1'b0;
      ack_id     <= '0;
      eoi_pulse  <= 1'b0;
      eoi_id     <= '0;
      eoi_err    <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: ctl_en <= reg_wdata[0];
          A_MASK: pmask  <= reg_wdata[PRIO_W-1:0];
          A_BPT:  bpt    <= reg_wdata[2:0];
          default: ;
        endcase
      end
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
      irq_out   <= allow;
      ack_pulse <= take;
      if (take) ack_id <= cand_id;
      eoi_pulse <= eoi_hit;
      if (eoi_hit) eoi_id <= top_id;
      if (eoi_miss) eoi_err <= 1'b1;
    end
  end

  assert_ack_not_spurious_R4: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |-> (ack_id != SPUR_ID));
  assert_ack_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |=> !ack_pulse || $past(reg_rd));
  assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_pulse, eoi_pulse}));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    eoi_err |=> eoi_err);
  assert_irq_needs_enable_R1: assert property (@(posedge clk) disable iff (rst)
    take |=> $past(ctl_en) && $past(dist_en));
  assert_irq_below_mask_R2: assert property (@(posedge clk) disable iff (rst)
    allow |-> (cand_prio < pmask));
endmodule

// File: tb/cpuif_top_bench.sv
module cpuif_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SPUR = 1023;

  logic        clk = 0, rst = 1;
  logic        dist_en = 0, cand_valid = 0;
  logic [9:0]  cand_id = 0;
  logic [7:0]  cand_prio = 0;
  logic        reg_rd = 0, reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        reg_rvalid, irq_out, ack_pulse, eoi_pulse, eoi_err;
  logic [9:0]  ack_id, eoi_id;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuif_top u_cpuif_top (
    .clk(clk), .rst(rst), .dist_en(dist_en), .cand_valid(cand_valid),
    .cand_id(cand_id), .cand_prio(cand_prio), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq_out(irq_out), .ack_pulse(ack_pulse),
    .ack_id(ack_id), .eoi_pulse(eoi_pulse), .eoi_id(eoi_id), .eoi_err(eoi_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int d, output bit pulse);
    reg_rd = 1; reg_addr = a;
    tick();
    reg_rd = 0;
    d = int'(reg_rdata);
    pulse = ack_pulse;
  endtask

  task automatic offer(input int id, input int prio);
    cand_valid = 1; cand_id = 10'(id); cand_prio = 8'(prio);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d;
    bit p;
    int v;
    repeat (3) tick();
    rst = 0;
    tick();
    // R10 / R8: reset state
    chk(irq_out == 0, "R1 reset irq", irq_out, 0);
    chk(eoi_err == 0, "R7 reset err", eoi_err, 0);
    rd(3'd0, d, p); chk(d == 0 && reg_rvalid, "R10 ctrl reset", d, 0);
    rd(3'd1, d, p); chk(d == 0, "R10 mask reset", d, 0);
    rd(3'd5, d, p); chk(d == 255, "R8 idle running", d, 255);

    // R10 readback
    wr(3'd1, 32'hFF); wr(3'd2, 32'd5);
    rd(3'd1, d, p); chk(d == 255, "R10 mask readback", d, 255);
    rd(3'd2, d, p); chk(d == 5, "R10 bpt readback", d, 5);
    wr(3'd2, 0);

    // R1 / R5: interface disabled
    dist_en = 1; offer(33, 16'h10); tick(); tick();
    chk(irq_out == 0, "R1 ctl off irq", irq_out, 0);
    rd(3'd3, d, p); chk(d == SPUR && !p, "R5 ctl off ack", d, SPUR);
    wr(3'd0, 1); tick();
    chk(irq_out == 1, "R1 enabled irq", irq_out, 1);
    dist_en = 0; tick();
    chk(irq_out == 0, "R1 dist off irq", irq_out, 0);
    rd(3'd3, d, p); chk(d == SPUR && !p, "R5 dist off ack", d, SPUR);
    rd(3'd6, d, p); chk(d == SPUR, "R9 hpp dist off", d, SPUR);
    dist_en = 1;

    // R2: mask sweep
    for (int m = 1; m < 256; m++) begin
      wr(3'd1, 32'(m));
      offer(7, m); tick();
      chk(irq_out == 0, "R2 prio equal mask", irq_out, 0);
      offer(7, m - 1); tick();
      chk(irq_out == 1, "R2 prio below mask", irq_out, 1);
    end
    wr(3'd1, 32'hFF);

    // R9: highest pending, no side effect
    offer(77, 8'h30); tick();
    rd(3'd6, d, p); chk(d == 77 && !p, "R9 hpp id", d, 77);
    rd(3'd5, d, p); chk(d == 255, "R9 no activate", d, 255);
    cand_valid = 0; tick();
    rd(3'd6, d, p); chk(d == SPUR, "R9 hpp none", d, SPUR);
    rd(3'd3, d, p); chk(d == SPUR && !p, "R5 no candidate", d, SPUR);

    // R3 / R4 / R6: preemption sweep
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 4; k++) begin
        int p1;
        p1 = (k == 0) ? 8'h40 : (k == 1) ? 8'h41 : (k == 2) ? 8'h87 : 8'hC0;
        wr(3'd2, 32'(b));
        offer(5, p1);
        rd(3'd3, d, p);
        chk(d == 5, "R4 ack id", d, 5);
        chk(p == 1 && ack_id == 5, "R4 ack pulse", int'(ack_id), 5);
        tick();
        chk(ack_pulse == 0, "R4 pulse width", ack_pulse, 0);
        rd(3'd5, d, p); chk(d == p1, "R8 running", d, p1);
        for (int p2 = 0; p2 < 255; p2 += 7) begin
          offer(6, p2); tick();
          v = ((p2 >> (b + 1)) < (p1 >> (b + 1))) ? 1 : 0;
          chk(irq_out == v, "R3 preempt", irq_out, v);
        end
        cand_valid = 0;
        wr(3'd4, 5); 
        chk(eoi_pulse == 1 && eoi_id == 5, "R6 eoi pulse", int'(eoi_id), 5);
        rd(3'd5, d, p); chk(d == 255, "R6 priority drop", d, 255);
      end
    end

    // R5 / R6 / R7: fill stack with binary point 0
    wr(3'd2, 0);
    for (int k = 0; k < 8; k++) begin
      offer(k + 1, 8'h80 - 8'h10 * k);
      rd(3'd3, d, p);
      chk(d == k + 1, "R4 nested ack", d, k + 1);
    end
    offer(20, 0); tick(); tick();
    chk(irq_out == 0, "R5 full irq", irq_out, 0);
    rd(3'd3, d, p); chk(d == SPUR && !p, "R5 full ack", d, SPUR);
    cand_valid = 0;
    wr(3'd4, 1);
    chk(eoi_pulse == 0, "R7 miss no pulse", eoi_pulse, 0);
    chk(eoi_err == 1, "R7 err set", eoi_err, 1);
    rd(3'd5, d, p); chk(d == 8'h10, "R7 stack kept", d, 16);
    for (int k = 7; k >= 0; k--) begin
      wr(3'd4, 32'(k + 1));
      chk(eoi_pulse == 1 && eoi_id == k + 1, "R6 nested eoi", int'(eoi_id), k + 1);
      rd(3'd5, d, p);
      v = (k == 0) ? 255 : 8'h80 - 8'h10 * (k - 1);
      chk(d == v, "R6 running after eoi", d, v);
    end
    wr(3'd4, 3);
    chk(eoi_pulse == 0 && eoi_err == 1, "R7 empty eoi", eoi_err, 1);
    tick();
    chk(eoi_err == 1, "R7 sticky", eoi_err, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule